// File: doc/BRIEF.md
# Scanline Buffer Colour Decoder

This block walks a 320-entry scanline buffer from the leftmost entry to the rightmost. A single pulse on `line_start` begins each walk. Each buffer entry is 5 bits wide. For every entry the block produces a 5-bit colour index. How the entry's bits are mapped depends on a 2-bit read mode and on whether the pixel index is even or odd. The colour indices leave as a valid/ready stream, and the 320th index of each line carries an end-of-line flag. The palette lookup, the video timing and the writing of the buffer are handled by neighbouring logic.

The buffer read port has zero latency. The block drives `buf_rd_addr` and asserts `buf_rd_en` in the cycle it consumes an entry, and it expects `buf_rd_data` to reflect that address in the same cycle. One output register sits between the decoder and the stream. If the consumer holds `px_ready` high, one pixel leaves per clock. If `px_ready` is low while `px_valid` is high, the pending pixel and its flag are held unchanged and the scan pauses. No buffer read happens until that pixel is accepted. A beat transfers on any clock edge where both `px_valid` and `px_ready` are high.

The read mode is captured when the line starts and applies to all 320 pixels of that line. A `line_start` pulse that arrives while a line is still being scanned has no effect.

Top module: `linebuf_color_scan`

## Requirements
- R1: After reset, `px_valid`, `px_last` and `buf_rd_en` are low, and no scan is in progress.
- R2: A `line_start` pulse while idle captures `read_mode` and begins the scan at index 0. The address then advances by one for each entry read (`buf_rd_en` high), and `buf_rd_data` is taken in the same cycle as its address.
- R3: Read mode 0 (`read_mode` = 2'b00) outputs the buffer entry D[4:0] unchanged as the colour index.
- R4: Read mode 1 (2'b01) is reserved and decodes exactly like read mode 0.
- R5: Read mode 2 (2'b10) outputs {D4, 0, 0, D1, D3} for an even pixel and {D4, 0, 0, D0, D2} for an odd pixel (MSB first).
- R6: Read mode 3 (2'b11) outputs {D4, D3, D2, D1, 0} for an even pixel and {D4, D3, D2, D0, 0} for an odd pixel (MSB first).
- R7: Pixel parity is the parity of the entry index within the line. Index 0 is even.
- R8: Each line yields exactly 320 accepted beats. `px_last` is high on the 320th beat only, and `px_valid` falls once that beat is accepted, unless a new line has been started.
- R9: While `px_valid` is high and `px_ready` is low, `px_color` and `px_last` stay stable, and no beat is lost or repeated.
- R10: While a line is in progress, changes on `read_mode` and further `line_start` pulses have no effect on that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that begins a line scan |
| read_mode | input | 2 | Decode mode, captured at line start |
| buf_rd_en | output | 1 | Buffer entry is consumed this cycle |
| buf_rd_addr | output | 9 | Index of the buffer entry being read |
| buf_rd_data | input | 5 | Buffer entry at `buf_rd_addr`, same cycle |
| px_valid | output | 1 | Colour index stream valid |
| px_ready | input | 1 | Consumer accepts a colour index |
| px_color | output | 5 | Decoded colour index |
| px_last | output | 1 | Marks the 320th colour index of the line |

## Verification
The hardest case to reach is a stall on the final pixel of a line, combined with a stray `line_start` and a changing `read_mode` arriving mid-line. In that case the end-of-line flag, the parity and the captured mode must all survive pauses of unpredictable length. The stimulus therefore switches between three `px_ready` patterns: always ready, mostly ready, and mostly stalled. Lines that receive an extra start pulse and a flipped mode partway through are interleaved with ordinary lines. Every accepted beat is compared against an independently computed colour and end flag. Held beats are compared against the value seen on the previous cycle.

// File: rtl/linebuf_scan_pkg.sv
package linebuf_scan_pkg;

  localparam int ENT_W = 5;

  typedef logic [ENT_W-1:0] ent_t;

  typedef enum logic [1:0] {
    RM_DIRECT   = 2'b00,
    RM_RESERVED = 2'b01,
    RM_PAIR     = 2'b10,
    RM_QUAD     = 2'b11
  } rd_mode_e;

endpackage

// File: rtl/linebuf_scan_ctr.sv
module linebuf_scan_ctr
  import linebuf_scan_pkg::*;
#(
  parameter int LINE_LEN = 320,
  localparam int IDX_W = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  rd_mode_e         mode_i,
  input  logic             advance_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_idx_o,
  output rd_mode_e         mode_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  rd_mode_e         mode_q;

  // Mode is latched only when idle; a running line ignores new starts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      mode_q   <= RM_DIRECT;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        mode_q   <= mode_i;
      end
    end else if (advance_i) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active_o   = active_q;
  assign idx_o      = idx_q;
  assign last_idx_o = (idx_q == LAST_IDX);
  assign mode_o     = mode_q;

  // R2
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> (idx_q == '0));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && advance_i && !last_idx_o |=> active_q && (idx_q == $past(idx_q) + 1'b1));

  // R8
  line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && advance_i && last_idx_o |=> !active_q);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !(advance_i && last_idx_o) |=> active_q && $stable(mode_q));

  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !advance_i |=> $stable(idx_q));

endmodule

// File: rtl/linebuf_color_dec.sv
module linebuf_color_dec
  import linebuf_scan_pkg::*;
(
  input  ent_t     ent_i,
  input  rd_mode_e mode_i,
  input  logic     odd_i,
  output ent_t     color_o
);

  always_comb begin
    unique case (mode_i)
      RM_PAIR: begin
        color_o = odd_i ? {ent_i[4], 2'b00, ent_i[0], ent_i[2]}
                        : {ent_i[4], 2'b00, ent_i[1], ent_i[3]};
      end
      RM_QUAD: begin
        color_o = {ent_i[4], ent_i[3], ent_i[2], (odd_i ? ent_i[0] : ent_i[1]), 1'b0};
      end
      default: begin
        color_o = ent_i;
      end
    endcase
  end

endmodule

// File: rtl/linebuf_out_stage.sv
module linebuf_out_stage #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic         ready_i,
  output logic         accept_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         last_o
);

  logic         valid_q;
  logic [W-1:0] data_q;
  logic         last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
      last_q  <= last_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end
  end

  assign accept_o = !valid_q || ready_i;
  assign valid_o  = valid_q;
  assign data_o   = data_q;
  assign last_o   = last_q;

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !ready_i |=> valid_q && $stable(data_q) && $stable(last_q));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> accept_o);

  // R8
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> valid_q);

endmodule

// File: rtl/linebuf_color_scan.sv
module linebuf_color_scan
  import linebuf_scan_pkg::*;
#(
  parameter int LINE_LEN = 320,
  localparam int IDX_W = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [1:0]       read_mode,
  output logic             buf_rd_en,
  output logic [IDX_W-1:0] buf_rd_addr,
  input  logic [ENT_W-1:0] buf_rd_data,
  output logic             px_valid,
  input  logic             px_ready,
  output logic [ENT_W-1:0] px_color,
  output logic             px_last
);

  logic             active;
  logic [IDX_W-1:0] idx;
  logic             last_idx;
  rd_mode_e         mode_q;
  logic             accept;
  logic             advance;
  ent_t             color;

  assign advance     = active && accept;
  assign buf_rd_en   = advance;
  assign buf_rd_addr = idx;

  linebuf_scan_ctr #(.LINE_LEN(LINE_LEN)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (line_start),
    .mode_i    (rd_mode_e'(read_mode)),
    .advance_i (advance),
    .active_o  (active),
    .idx_o     (idx),
    .last_idx_o(last_idx),
    .mode_o    (mode_q)
  );

  linebuf_color_dec u_dec (
    .ent_i  (buf_rd_data),
    .mode_i (mode_q),
    .odd_i  (idx[0]),
    .color_o(color)
  );

  linebuf_out_stage #(.W(ENT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (advance),
    .data_i  (color),
    .last_i  (last_idx),
    .ready_i (px_ready),
    .accept_o(accept),
    .valid_o (px_valid),
    .data_o  (px_color),
    .last_o  (px_last)
  );

  // Count accepted beats per line, for the end-flag check only.
  logic [IDX_W-1:0] beat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
    end else if (px_valid && px_ready) begin
      beat_cnt <= px_last ? '0 : beat_cnt + 1'b1;
    end
  end

  // R8
  last_on_final_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && px_ready && px_last |-> (beat_cnt == IDX_W'(LINE_LEN - 1)));

  // R3
  direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en && (mode_q == RM_DIRECT) |=> (px_color == $past(buf_rd_data)));

  // R4
  reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en && (mode_q == RM_RESERVED) |=> (px_color == $past(buf_rd_data)));

  // R5
  pair_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en && (mode_q == RM_PAIR) |=> (px_color[3:2] == 2'b00) && (px_color[4] == $past(buf_rd_data[4])));

  // R6
  quad_zero_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en && (mode_q == RM_QUAD) |=> (px_color[0] == 1'b0) && (px_color[4:2] == $past(buf_rd_data[4:2])));

  // R1
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !buf_rd_en);

endmodule

// File: tb/linebuf_color_scan_tb.sv
module linebuf_color_scan_tb;

  localparam int N = 320;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_start;
  logic [1:0] read_mode;
  logic       buf_rd_en;
  logic [8:0] buf_rd_addr;
  logic [4:0] buf_rd_data;
  logic       px_valid;
  logic       px_ready;
  logic [4:0] px_color;
  logic       px_last;

  always #10 clk = ~clk;

  logic [4:0] mem [0:N-1];
  assign buf_rd_data = (buf_rd_addr < 9'(N)) ? mem[buf_rd_addr] : 5'd0;

  linebuf_color_scan u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .read_mode  (read_mode),
    .buf_rd_en  (buf_rd_en),
    .buf_rd_addr(buf_rd_addr),
    .buf_rd_data(buf_rd_data),
    .px_valid   (px_valid),
    .px_ready   (px_ready),
    .px_color   (px_color),
    .px_last    (px_last)
  );

  int errors = 0;
  int checks = 0;
  int beat_k = 0;
  int ready_style = 0;
  logic [1:0] line_mode = 2'b00;
  logic       prev_stall = 1'b0;
  logic [4:0] prev_color = '0;
  logic       prev_last = 1'b0;
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_color(input logic [4:0] d, input logic [1:0] m, input bit odd);
    logic [4:0] r;
    case (m)
      2'b10: begin
        r = 5'd0;
        r[4] = d[4];
        r[1] = odd ? d[0] : d[1];
        r[0] = odd ? d[2] : d[3];
      end
      2'b11: begin
        r = d;
        r[1] = odd ? d[0] : d[1];
        r[0] = 1'b0;
      end
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00: return "R3 R7 mode0";
      2'b01: return "R4 R7 mode1";
      2'b10: return "R5 R7 mode2";
      default: return "R6 R7 mode3";
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Stream monitor: drive ready at the falling edge, sample 1 ns later.
  always begin
    @(negedge clk);
    case (ready_style)
      0: px_ready = 1'b1;
      1: px_ready = (($urandom % 3) != 0);
      default: px_ready = (($urandom % 5) == 0);
    endcase
    #1;
    if (rst_n === 1'b1) begin
      if (prev_stall) begin
        // R9 held beat must not change
        chk(px_valid && (px_color == prev_color) && (px_last == prev_last),
            "R9 stall hold", int'(px_color), int'(prev_color));
      end
      if (px_valid && px_ready) begin
        if (beat_k >= N) begin
          chk(1'b0, "R8 extra beat", beat_k + 1, N);
        end else begin
          chk(px_color == exp_color(mem[beat_k], line_mode, beat_k[0]),
              mode_req(line_mode), int'(px_color),
              int'(exp_color(mem[beat_k], line_mode, beat_k[0])));
          chk(px_last == (beat_k == N - 1), "R8 end flag", int'(px_last), int'(beat_k == N - 1));
          beat_k++;
        end
      end
      prev_stall = px_valid && !px_ready;
      prev_color = px_color;
      prev_last  = px_last;
    end
  end

  task automatic fill(input int pat);
    for (int i = 0; i < N; i++) begin
      case (pat)
        0: mem[i] = 5'(i);
        1: mem[i] = 5'h1F;
        2: mem[i] = i[0] ? 5'h0A : 5'h15;
        default: mem[i] = 5'($urandom);
      endcase
    end
  endtask

  task automatic run_line(input logic [1:0] m, input int style, input int pat, input bit poke);
    fill(pat);
    ready_style = style;
    @(negedge clk);
    beat_k     = 0;
    line_mode  = m;
    read_mode  = m;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    read_mode  = ~m;
    #2;
    // R2 scan starts at index 0
    chk(buf_rd_addr == 9'd0 || beat_k > 0, "R2 start index", int'(buf_rd_addr), 0);
    if (style == 0) chk(buf_rd_en == 1'b1, "R2 first read", int'(buf_rd_en), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      // R10 stray start and new mode mid-line
      line_start = 1'b1;
      read_mode  = 2'($urandom);
      @(negedge clk);
      line_start = 1'b0;
      read_mode  = 2'($urandom);
    end
    while (beat_k < N) @(negedge clk);
    ready_style = 0;
    repeat (4) @(negedge clk);
    #2;
    // R8 and R10 exactly N beats per line
    chk(beat_k == N, "R8 R10 beat count", beat_k, N);
    chk(!px_valid && !buf_rd_en, "R8 idle after line", int'(px_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0;
    line_start = 1'b0;
    read_mode = 2'b00;
    fill(3);
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(!px_valid && !px_last && !buf_rd_en, "R1 reset", int'(px_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(!px_valid && !buf_rd_en, "R1 idle", int'(buf_rd_en), 0);

    run_line(2'b00, 0, 0, 1'b0);
    run_line(2'b01, 0, 0, 1'b0);
    run_line(2'b10, 0, 2, 1'b0);
    run_line(2'b11, 0, 2, 1'b0);
    run_line(2'b10, 1, 1, 1'b1);
    run_line(2'b11, 2, 3, 1'b1);
    run_line(2'b00, 2, 3, 1'b1);
    run_line(2'b01, 1, 3, 1'b1);
    for (int l = 0; l < 6; l++) begin
      run_line(2'($urandom), 1 + (l % 2), 3, bit'(l % 2));
    end
    done = 1'b1;
    finish_run();
  end

endmodule